// File: doc/BRIEF.md
# Holdover and Monotonic Time Restore Controller

This block owns a device's local time-of-day counter while the network time reference comes and goes. Each clock cycle the counter advances by a nominal increment. A servo outside the block reports the phase error between the reference and the local time once per update slot. The controller keeps that error as a residual and works it off by stretching or shrinking the per-cycle increment by a small, bounded amount. The counter therefore never moves backward, and no single cycle sees a large jump, with one exception: a forward error larger than a threshold may be stepped, but only while the block is restoring lock.

A three-state machine sequences the behaviour:

- **DISCIPLINED**: the block is locked and slews to the servo corrections.
- **HOLDOVER**: the block free-runs on the local timebase and ignores corrections.
- **RESTORE**: the reference has returned and the block is converging back to lock.

The transitions are named as follows:

- **loss** (DISCIPLINED or RESTORE to HOLDOVER) is caused by the reference going invalid, by a power-restore event, or by too many missed updates in a row.
- **reacquire** (HOLDOVER to RESTORE) happens on the first valid update while the reference is good.
- **lock** (RESTORE to DISCIPLINED) happens after a run of small errors.

Loss and reacquire each emit a one-cycle marker that carries the timestamp, for audit logging. Backward error requests beyond the threshold are counted as monotonic violations and are slewed rather than stepped.

Top module: `holdover_restore_ctrl`

## Requirements
- R1: After reset the state code is HOLDOVER. The codes are DISCIPLINED = 2'b00, HOLDOVER = 2'b01 and RESTORE = 2'b10. After reset `tod` is 0, both markers are low and `viol_cnt` is 0.
- R2: `tod` rises on every clock cycle outside reset. With no residual pending it rises by exactly INC_NOM.
- R3: In DISCIPLINED or RESTORE, the block moves to HOLDOVER on the next edge in any of these cases: `ref_ok` is low, `pwr_restore` is high, or a slot without a valid update brings the count of consecutive missed slots to `miss_limit`. Any update in that cycle is ignored, and the residual is cleared.
- R4: Each move into HOLDOVER raises `mark_enter` for one cycle after the edge. At the same time `mark_ts` holds the value `tod` had before that edge. Reset emits no marker.
- R5: In HOLDOVER, `tod` advances by exactly INC_NOM and updates have no effect, until a slot carries a valid update while `ref_ok` is high and `pwr_restore` is low. That slot moves the state to RESTORE, is applied under RESTORE rules, and raises `mark_exit` with `mark_ts` set as in R4.
- R6: An accepted update whose error is not stepped replaces the residual with the error clamped to ±CORR_MAX. Each cycle adds to the increment the residual clamped to ±SLEW_MAX and removes that amount from the residual.
- R7: While the state is RESTORE or HOLDOVER, an accepted error greater than `step_thresh` is added to `tod` in one cycle in place of the slew amount, and the residual becomes 0.
- R8: An accepted error less than −`step_thresh` increments `viol_cnt` by one and is slewed, never stepped.
- R9: In RESTORE, every accepted update with |error| < `lock_thresh` extends a run of consecutive updates, and any other accepted update restarts the run. When the run reaches `lock_count`, the state moves to DISCIPLINED. The update that causes reacquire does not count toward the run.
- R10: In DISCIPLINED, a forward error above `step_thresh` is slewed, so `tod` never rises by more than INC_NOM+SLEW_MAX in one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one counter tick per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_ok | input | 1 | Time reference is currently valid |
| pwr_restore | input | 1 | Power-restore event pulse; forces holdover |
| upd_slot | input | 1 | Marks a cycle in which a servo update is expected |
| upd_valid | input | 1 | The expected update is present (qualified by upd_slot) |
| upd_err | input | ERR_W | Signed phase error, reference minus local, in counter units |
| step_thresh | input | ERR_W-1 | Magnitude above which an error counts as a step request |
| lock_thresh | input | ERR_W-1 | Magnitude below which an error counts toward lock |
| lock_count | input | CNT_W | Consecutive small-error updates needed for lock |
| miss_limit | input | CNT_W | Consecutive missed slots that declare loss |
| tod | output | TOD_W | Local time-of-day counter |
| state_o | output | 2 | State code (see R1) |
| mark_enter | output | 1 | One-cycle marker: entered holdover |
| mark_exit | output | 1 | One-cycle marker: left holdover |
| mark_ts | output | TOD_W | Timestamp carried by the markers |
| viol_cnt | output | VIOL_W | Count of backward step requests |

## Verification
The bench sends a long arithmetic stream of reference drops, power events, missed slots and errors of both signs and of every size class. It compares every cycle against a model built from the requirements.

Three corner cases get particular attention:

- **Boundary between a stepped and a slewed forward error.** A design that stepped in DISCIPLINED would show a jump of hundreds of units in one cycle. A design that forgot to step on reacquire would crawl at SLEW_MAX per cycle.
- **Miss counting.** A counter that failed to clear on a present update would declare loss too early. An off-by-one would enter holdover a slot late.
- **Broken lock runs.** A run interrupted by one large error must restart. A design that did not restart it would reach DISCIPLINED while still far off.

Backward errors are driven just below and just above the threshold. A design that stepped them would break the rise of `tod`, and a design that miscounted them would show a wrong `viol_cnt`.

// File: rtl/hrc_pkg.sv
package hrc_pkg;
    typedef enum logic [1:0] {
        ST_DISC = 2'b00,
        ST_HOLD = 2'b01,
        ST_REST = 2'b10
    } hrc_state_e;
endpackage

// File: rtl/hrc_seq.sv
module hrc_seq
    import hrc_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_ok,
    input  logic             pwr_restore,
    input  logic             upd_slot,
    input  logic             upd_valid,
    input  logic             near_lock,
    input  logic [CNT_W-1:0] miss_limit,
    input  logic [CNT_W-1:0] lock_count,
    output hrc_state_e       state_q,
    output logic             accept,
    output logic             go_hold,
    output logic             go_rest
);
    hrc_state_e       state_d;
    logic [CNT_W-1:0] miss_q, miss_d;
    logic [CNT_W-1:0] run_q, run_d;
    logic             present, missed, loss, run_done;

    assign present  = upd_slot && upd_valid;
    assign missed   = upd_slot && !upd_valid;
    assign loss     = !ref_ok || pwr_restore ||
                      (missed && (({1'b0, miss_q} + 1'b1) >= {1'b0, miss_limit}));
    assign run_done = ({1'b0, run_q} + 1'b1) >= {1'b0, lock_count};

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_HOLD;
            miss_q  <= '0;
            run_q   <= '0;
        end else begin
            state_q <= state_d;
            miss_q  <= miss_d;
            run_q   <= run_d;
        end
    end

    // next state and counters
    always_comb begin
        state_d = state_q;
        miss_d  = miss_q;
        run_d   = run_q;
        unique case (state_q)
            ST_HOLD: begin
                miss_d = '0;
                run_d  = '0;
                if (ref_ok && !pwr_restore && present) begin
                    state_d = ST_REST;
                end
            end
            ST_REST: begin
                if (loss) begin
                    state_d = ST_HOLD;
                    miss_d  = '0;
                    run_d   = '0;
                end else begin
                    if (missed) miss_d = miss_q + 1'b1;
                    if (present) begin
                        miss_d = '0;
                        if (near_lock) begin
                            if (run_done) begin
                                state_d = ST_DISC;
                                run_d   = '0;
                            end else begin
                                run_d = run_q + 1'b1;
                            end
                        end else begin
                            run_d = '0;
                        end
                    end
                end
            end
            ST_DISC: begin
                run_d = '0;
                if (loss) begin
                    state_d = ST_HOLD;
                    miss_d  = '0;
                end else begin
                    if (missed)  miss_d = miss_q + 1'b1;
                    if (present) miss_d = '0;
                end
            end
            default: begin
                state_d = ST_HOLD;
                miss_d  = '0;
                run_d   = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        accept  = 1'b0;
        go_hold = 1'b0;
        go_rest = 1'b0;
        unique case (state_q)
            ST_HOLD: begin
                go_rest = ref_ok && !pwr_restore && present;
                accept  = go_rest;
            end
            ST_REST, ST_DISC: begin
                go_hold = loss;
                accept  = present && !loss;
            end
            default: ;
        endcase
    end

    p_lock_run_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DISC && $past(state_q) == ST_REST) |->
            $past(upd_slot && upd_valid && near_lock));

    p_reacquire_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_REST && $past(state_q) == ST_HOLD) |->
            $past(ref_ok && upd_slot && upd_valid && !pwr_restore));

    p_loss_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD && $past(state_q) != ST_HOLD && $past(rst_n)) |->
            $past(!ref_ok || pwr_restore || (upd_slot && !upd_valid)));
endmodule

// File: rtl/hrc_slew.sv
module hrc_slew #(
    parameter int ERR_W    = 20,
    parameter int SLEW_MAX = 8,
    parameter int CORR_MAX = 50000
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load,
    input  logic                     clr,
    input  logic signed [ERR_W:0]    err_x,
    output logic signed [ERR_W:0]    adj
);
    localparam int EW = ERR_W + 1;
    localparam logic signed [EW-1:0] SLEW_S = EW'(SLEW_MAX);
    localparam logic signed [EW-1:0] CORR_S = EW'(CORR_MAX);

    logic signed [EW-1:0] res_q, res_d, err_c;

    always_comb begin
        if (res_q > SLEW_S)       adj = SLEW_S;
        else if (res_q < -SLEW_S) adj = -SLEW_S;
        else                      adj = res_q;
    end

    always_comb begin
        if (err_x > CORR_S)       err_c = CORR_S;
        else if (err_x < -CORR_S) err_c = -CORR_S;
        else                      err_c = err_x;
    end

    always_comb begin
        if (clr)       res_d = '0;
        else if (load) res_d = err_c;
        else           res_d = res_q - adj;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    p_resid_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (res_q <= CORR_S) && (res_q >= -CORR_S));

    p_resid_shrinks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(load) && !$past(clr) && $past(res_q) > 0) |->
            (res_q >= 0 && res_q < $past(res_q)));
endmodule

// File: rtl/hrc_tod.sv
module hrc_tod #(
    parameter int TOD_W    = 48,
    parameter int ERR_W    = 20,
    parameter int INC_NOM  = 8000,
    parameter int SLEW_MAX = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  step,
    input  logic signed [ERR_W:0] adj,
    input  logic signed [ERR_W:0] err_x,
    output logic [TOD_W-1:0]      tod_q
);
    localparam int EW = ERR_W + 1;
    localparam logic [TOD_W-1:0] INC_T = TOD_W'(INC_NOM);
    localparam logic [TOD_W-1:0] LO_T  = TOD_W'(INC_NOM - SLEW_MAX);
    localparam logic [TOD_W-1:0] HI_T  = TOD_W'(INC_NOM + SLEW_MAX);

    logic signed [EW-1:0] delta;
    logic [TOD_W-1:0]     delta_t;

    assign delta   = step ? err_x : adj;
    assign delta_t = {{(TOD_W-EW){delta[EW-1]}}, delta};

    always_ff @(posedge clk) begin
        if (!rst_n) tod_q <= '0;
        else        tod_q <= tod_q + INC_T + delta_t;
    end

    p_monotonic_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> tod_q > $past(tod_q));

    p_slew_rate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(step)) |->
            ((tod_q - $past(tod_q)) >= LO_T && (tod_q - $past(tod_q)) <= HI_T));
endmodule

// File: rtl/holdover_restore_ctrl.sv
module holdover_restore_ctrl
    import hrc_pkg::*;
#(
    parameter int TOD_W    = 48,
    parameter int ERR_W    = 20,
    parameter int INC_NOM  = 8000,
    parameter int SLEW_MAX = 8,
    parameter int CORR_MAX = 50000,
    parameter int CNT_W    = 8,
    parameter int VIOL_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_ok,
    input  logic              pwr_restore,
    input  logic              upd_slot,
    input  logic              upd_valid,
    input  logic [ERR_W-1:0]  upd_err,
    input  logic [ERR_W-2:0]  step_thresh,
    input  logic [ERR_W-2:0]  lock_thresh,
    input  logic [CNT_W-1:0]  lock_count,
    input  logic [CNT_W-1:0]  miss_limit,
    output logic [TOD_W-1:0]  tod,
    output logic [1:0]        state_o,
    output logic              mark_enter,
    output logic              mark_exit,
    output logic [TOD_W-1:0]  mark_ts,
    output logic [VIOL_W-1:0] viol_cnt
);
    localparam int EW = ERR_W + 1;
    localparam logic [TOD_W-1:0] INC_T = TOD_W'(INC_NOM);
    localparam logic [TOD_W-1:0] HI_T  = TOD_W'(INC_NOM + SLEW_MAX);

    hrc_state_e           state_q;
    logic                 accept, go_hold, go_rest;
    logic                 near_lock, step_fwd, back_req;
    logic signed [EW-1:0] err_x, sthr_x, lthr_x, abs_x, adj;

    assign err_x     = $signed({upd_err[ERR_W-1], upd_err});
    assign sthr_x    = $signed({2'b00, step_thresh});
    assign lthr_x    = $signed({2'b00, lock_thresh});
    assign abs_x     = err_x[EW-1] ? -err_x : err_x;
    assign near_lock = abs_x < lthr_x;
    assign step_fwd  = accept && (state_q != ST_DISC) && (err_x > sthr_x);
    assign back_req  = accept && (err_x < -sthr_x);
    assign state_o   = state_q;

    hrc_seq #(.CNT_W(CNT_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .ref_ok(ref_ok), .pwr_restore(pwr_restore),
        .upd_slot(upd_slot), .upd_valid(upd_valid), .near_lock(near_lock),
        .miss_limit(miss_limit), .lock_count(lock_count),
        .state_q(state_q), .accept(accept), .go_hold(go_hold), .go_rest(go_rest)
    );

    hrc_slew #(.ERR_W(ERR_W), .SLEW_MAX(SLEW_MAX), .CORR_MAX(CORR_MAX)) u_slew (
        .clk(clk), .rst_n(rst_n), .load(accept), .clr(go_hold || step_fwd),
        .err_x(err_x), .adj(adj)
    );

    hrc_tod #(.TOD_W(TOD_W), .ERR_W(ERR_W), .INC_NOM(INC_NOM), .SLEW_MAX(SLEW_MAX)) u_tod (
        .clk(clk), .rst_n(rst_n), .step(step_fwd), .adj(adj), .err_x(err_x), .tod_q(tod)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mark_enter <= 1'b0;
            mark_exit  <= 1'b0;
            mark_ts    <= '0;
            viol_cnt   <= '0;
        end else begin
            mark_enter <= go_hold;
            mark_exit  <= go_rest;
            if (go_hold || go_rest) mark_ts <= tod;
            if (back_req) viol_cnt <= viol_cnt + 1'b1;
        end
    end

    p_enter_mark_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mark_enter |-> (state_q == ST_HOLD && mark_ts < tod));

    p_exit_mark_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mark_exit |-> (state_q == ST_REST && mark_ts < tod));

    p_hold_rate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && state_q == ST_HOLD && $past(state_q) == ST_HOLD) |->
            (tod - $past(tod)) == INC_T);

    p_no_disc_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && (tod - $past(tod)) > HI_T) |-> $past(state_q) != ST_DISC);

    p_viol_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && viol_cnt != $past(viol_cnt)) |->
            $past(upd_slot && upd_valid && ref_ok && !pwr_restore));
endmodule

// File: tb/test_holdover_restore_ctrl.sv
module test_holdover_restore_ctrl;
    localparam int CLK_PER = 10;
    localparam int TOD_W = 32, ERR_W = 12, INC = 100, SLEW = 3, CORR = 40;
    localparam int CNT_W = 8, VIOL_W = 16;
    localparam int STHR = 50, LTHR = 5, LCNT = 3, MLIM = 3;
    localparam int S_DISC = 0, S_HOLD = 1, S_REST = 2;

    logic clk = 1'b0, rst_n = 1'b0;
    logic ref_ok = 1'b0, pwr_restore = 1'b0, upd_slot = 1'b0, upd_valid = 1'b0;
    logic [ERR_W-1:0] upd_err = '0;
    logic [ERR_W-2:0] step_thresh = STHR, lock_thresh = LTHR;
    logic [CNT_W-1:0] lock_count = LCNT, miss_limit = MLIM;
    logic [TOD_W-1:0] tod, mark_ts;
    logic [1:0] state_o;
    logic mark_enter, mark_exit;
    logic [VIOL_W-1:0] viol_cnt;

    holdover_restore_ctrl #(.TOD_W(TOD_W), .ERR_W(ERR_W), .INC_NOM(INC), .SLEW_MAX(SLEW),
        .CORR_MAX(CORR), .CNT_W(CNT_W), .VIOL_W(VIOL_W)) i_holdover_restore_ctrl (
        .clk(clk), .rst_n(rst_n), .ref_ok(ref_ok), .pwr_restore(pwr_restore),
        .upd_slot(upd_slot), .upd_valid(upd_valid), .upd_err(upd_err),
        .step_thresh(step_thresh), .lock_thresh(lock_thresh), .lock_count(lock_count),
        .miss_limit(miss_limit), .tod(tod), .state_o(state_o), .mark_enter(mark_enter),
        .mark_exit(mark_exit), .mark_ts(mark_ts), .viol_cnt(viol_cnt)
    );

    always #(CLK_PER/2) clk = ~clk;

    int n_cmp = 0, n_bad = 0;
    bit done = 0;
    longint m_tod = 0, m_ts = 0, prev_tod = 0;
    int m_state = S_HOLD, m_res = 0, m_miss = 0, m_run = 0, m_viol = 0;
    bit m_me = 0, m_mx = 0;

    task automatic chk(input string tag, input longint act, input longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // expected behaviour for one edge, from the requirements
    task automatic model(input bit r, input bit p, input bit s, input bit v, input int e);
        int adj, n_state, n_res;
        longint n_tod;
        bit acc, loss;
        adj = (m_res > SLEW) ? SLEW : (m_res < -SLEW) ? -SLEW : m_res;
        n_state = m_state; n_res = m_res - adj; n_tod = m_tod + INC + adj;
        acc = 0; m_me = 0; m_mx = 0;
        if (m_state != S_HOLD) begin
            loss = !r || p || (s && !v && (m_miss + 1 >= MLIM));
            if (loss) begin
                n_state = S_HOLD; n_res = 0; m_me = 1; m_ts = m_tod; m_miss = 0; m_run = 0;
            end else begin
                if (s && !v) m_miss++;
                if (s && v) begin m_miss = 0; acc = 1; end
            end
        end else begin
            n_res = 0;
            if (r && !p && s && v) begin
                acc = 1; n_state = S_REST; m_mx = 1; m_ts = m_tod; m_run = 0; m_miss = 0;
            end
        end
        if (acc) begin
            if (e < -STHR) m_viol++;
            if (m_state != S_DISC && e > STHR) begin
                n_tod = m_tod + INC + e; n_res = 0;
            end else begin
                n_res = (e > CORR) ? CORR : (e < -CORR) ? -CORR : e;
            end
            if (m_state == S_REST) begin
                if ((e < 0 ? -e : e) < LTHR) begin
                    if (m_run + 1 >= LCNT) begin n_state = S_DISC; m_run = 0; end
                    else m_run++;
                end else m_run = 0;
            end
        end
        m_state = n_state; m_res = n_res; m_tod = n_tod;
    endtask

    task automatic cyc(input bit r, input bit p, input bit s, input bit v, input int e);
        ref_ok = r; pwr_restore = p; upd_slot = s; upd_valid = v; upd_err = ERR_W'(e);
        prev_tod = longint'(tod);
        @(posedge clk);
        model(r, p, s, v, e);
        @(negedge clk);
        chk("R2,R6,R7,R10 tod", longint'(tod), m_tod);
        chk("R2 monotonic", longint'(tod > TOD_W'(prev_tod)), 1);
        chk("R3,R5,R9 state", longint'(state_o), m_state);
        chk("R4 mark_enter", longint'(mark_enter), m_me);
        chk("R5 mark_exit", longint'(mark_exit), m_mx);
        if (m_me || m_mx) chk("R4,R5 mark_ts", longint'(mark_ts), m_ts);
        chk("R8 viol_cnt", longint'(viol_cnt), m_viol);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int unsigned x;
        int e;
        longint t0;
        repeat (4) @(negedge clk);
        // R1 reset state
        chk("R1 state", longint'(state_o), S_HOLD);
        chk("R1 tod", longint'(tod), 0);
        chk("R1 markers", longint'({mark_enter, mark_exit}), 0);
        chk("R1 viol", longint'(viol_cnt), 0);
        rst_n = 1'b1;
        // R5 free run in holdover, updates without reference ignored
        repeat (3) cyc(0, 0, 0, 0, 0);
        cyc(0, 0, 1, 1, 30);
        chk("R5 holdover ignores update", longint'(state_o), S_HOLD);
        // reacquire with small error, slewed
        cyc(1, 0, 1, 1, 20);
        repeat (8) cyc(1, 0, 0, 0, 0);
        // R9 lock run broken once
        cyc(1, 0, 1, 1, 2); cyc(1, 0, 1, 1, 2); cyc(1, 0, 1, 1, 9);
        chk("R9 run restarted", longint'(state_o), S_REST);
        cyc(1, 0, 1, 1, -2); cyc(1, 0, 1, 1, 1); cyc(1, 0, 1, 1, 0);
        chk("R9 locked", longint'(state_o), S_DISC);
        // R10 forward error in DISCIPLINED is slewed
        t0 = longint'(tod);
        cyc(1, 0, 1, 1, 300);
        chk("R10 no step", longint'(tod) - t0, INC);
        t0 = longint'(tod);
        cyc(1, 0, 0, 0, 0);
        chk("R6 slew step", longint'(tod) - t0, INC + SLEW);
        // R8 backward requests around threshold
        cyc(1, 0, 1, 1, -STHR);
        chk("R8 at threshold", longint'(viol_cnt), 0);
        cyc(1, 0, 1, 1, -STHR - 1);
        chk("R8 past threshold", longint'(viol_cnt), 1);
        repeat (20) cyc(1, 0, 0, 0, 0);
        // R3 miss counting: two misses, present, then limit
        cyc(1, 0, 1, 0, 0); cyc(1, 0, 1, 0, 0); cyc(1, 0, 1, 1, 0);
        cyc(1, 0, 1, 0, 0); cyc(1, 0, 1, 0, 0);
        chk("R3 before limit", longint'(state_o), S_DISC);
        cyc(1, 0, 1, 0, 0);
        chk("R3 miss limit", longint'(state_o), S_HOLD);
        // R7 forward step on reacquire
        t0 = longint'(tod);
        cyc(1, 0, 1, 1, 500);
        chk("R7 step", longint'(tod) - t0, INC + 500);
        cyc(1, 0, 1, 1, STHR + 1);
        // R3 power restore and reference drop
        cyc(1, 1, 1, 1, 2);
        chk("R3 power restore", longint'(state_o), S_HOLD);
        cyc(1, 0, 1, 1, -300);
        cyc(0, 0, 1, 1, 0);
        chk("R3 ref drop", longint'(state_o), S_HOLD);
        // long arithmetic sweep
        x = 32'h1234_5677;
        for (int i = 0; i < 3000; i++) begin
            x = x * 32'd1103515245 + 32'd12345;
            e = int'((x >> 8) % 241) - 120;
            if (x[29]) e = e * 4;
            if (x[3:1] == 3'd0) e = e % 4;
            cyc(x[19:16] != 4'd0, x[27:22] == 6'd0, x[12:11] != 2'b00, x[15:13] != 3'd0, e);
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule